// File: doc/BRIEF.md
# Reloadable Up/Down Address Counter with Bank Match

This block holds the running address for one port of a dual-ported line buffer. A chip instantiates it twice, once for the read side and once for the write side. Each copy steps its address by one on every clock edge where its enable is high. The direction bit picks whether it steps up or down, and the address wraps modulo 2^16 either way.

A reload strobe restarts the address. Depending on a mode bit, it either loads a programmed start value or clears to the origin for the current direction. The origin is all zeros when counting up and all ones when counting down.

A registered port-active flag tells the surrounding logic whether the current address belongs to this device. The flag is high only when the top three address bits equal a 3-bit bank number and the counter has not been left stale by a direction change. The flag gates the write strobe, or tristates the read data. It never stops the count: a device that sees a bank mismatch keeps stepping in lock-step with its neighbours.

Top module: `lb_addr_counter`

## Requirements
- R1: At a rising edge with `reload_stb`=1 and `reload_mode`=1, `addr_q` takes the value of `reload_val`.
- R2: At a rising edge with `reload_stb`=1 and `reload_mode`=0, `reload_val` is ignored. `addr_q` becomes 16'h0000 if `count_down`=0 and 16'hFFFF if `count_down`=1.
- R3: At a rising edge with `reload_stb`=0 and `step_en`=1, `addr_q` increments when `count_down`=0 and decrements when `count_down`=1, wrapping modulo 2^16 (FFFF+1=0000, 0000-1=FFFF).
- R4: At a rising edge with `reload_stb`=0 and `step_en`=0, `addr_q` keeps its value.
- R5: When `reload_stb`=1 and `step_en`=1 at the same edge, the reload (R1/R2) wins and no step is applied.
- R6: After each rising edge out of reset, `port_active` equals (`addr_q[15:13]` == the `bank_id` sampled at that edge) AND no reload is pending (R8). Bit 15 of `addr_q` pairs with bit 2 of `bank_id`.
- R7: A bank mismatch drives `port_active` low but does not stop `addr_q` from stepping while `step_en` is high.
- R8: A rising edge where `count_down` differs from its value at the previous edge marks a reload as pending, unless `reload_stb` is 1 at that edge. The value before the first edge counts as 0. A pending reload holds `port_active` low until the next edge with `reload_stb`=1.
- R9: While `rst_n` is low at a rising edge, `addr_q` becomes 0, `port_active` becomes 0 and no reload is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step_en | input | 1 | Step the address at this edge |
| reload_stb | input | 1 | Restart the address at this edge |
| reload_mode | input | 1 | 1 = load `reload_val`, 0 = clear to the direction's origin |
| count_down | input | 1 | 0 = count up, 1 = count down |
| reload_val | input | 16 | Programmed start address |
| bank_id | input | 3 | Bank number compared with the top address bits |
| addr_q | output | 16 | Current address |
| port_active | output | 1 | Port may access the array this cycle |

## Verification
A wrong next-address decision shows on `addr_q` one edge later. Because the address is a running state, the error then persists in every later cycle until a reload, so per-cycle comparison against an arithmetic model catches it at once. A stuck or missing pending-reload flag appears only through `port_active`, which stays high after a direction change or low after a reload. A wrong bank comparison shows within the 8192 steps it takes the top bits to move. Full 65,536-step sweeps in both directions cover every bank boundary and both wrap points.

// File: rtl/lbac_pkg.sv
// Shared types for the line-buffer address counter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lbac_pkg;

    // Direction encoding of the count_down input.
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } lbac_dir_e;

    // Next-address decision taken by the count core each edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } lbac_act_e;

endpackage

// File: rtl/lbac_count_core.sv
// Address register with reload, direction-aware clear and wrap-around step.
// Assumes: reload has priority over stepping; the width is at least 1.
// Exposes the next value so the bank gate can register a matching flag.
module lbac_count_core
    import lbac_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          reload_stb,
    input  logic          reload_mode,
    input  logic          count_down,
    input  logic [AW-1:0] reload_val,
    output logic [AW-1:0] addr_q,
    output logic [AW-1:0] addr_nxt
);

    localparam logic [AW-1:0] ORG_UP   = '0;
    localparam logic [AW-1:0] ORG_DOWN = '1;
    localparam logic [AW-1:0] ONE      = AW'(1);

    lbac_act_e act;

    // Pick this edge's action: reload first, then step, else hold.
    always_comb begin
        if (reload_stb) begin
            act = reload_mode ? ACT_LOAD : ACT_CLEAR;
        end else if (step_en) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    // Form the next address for the chosen action.
    always_comb begin
        unique case (act)
            ACT_LOAD:  addr_nxt = reload_val;
            ACT_CLEAR: addr_nxt = (count_down == DIR_DOWN) ? ORG_DOWN : ORG_UP;
            ACT_STEP:  addr_nxt = (count_down == DIR_DOWN) ? addr_q - ONE
                                                           : addr_q + ONE;
            default:   addr_nxt = addr_q;
        endcase
    end

    // Address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_nxt;
        end
    end

    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb && reload_mode |=> addr_q == $past(reload_val));

    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb && !reload_mode |=>
            addr_q == ($past(count_down) ? ORG_DOWN : ORG_UP));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_stb && step_en |=>
            addr_q == ($past(count_down) ? $past(addr_q) - ONE
                                         : $past(addr_q) + ONE));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reload_stb && !step_en |=> $stable(addr_q));

endmodule

// File: rtl/lbac_dir_guard.sv
// Tracks the count direction and raises a sticky "reload pending" flag
// when it changes without a reload strobe at the same edge.
// Assumes the direction reference after reset is "up".
module lbac_dir_guard
    import lbac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic count_down,
    input  logic reload_stb,
    output logic need_nxt,
    output logic need_q
);

    logic last_dir_q;

    // Pending flag: cleared by reload, set by a direction change, else held.
    always_comb begin
        if (reload_stb) begin
            need_nxt = 1'b0;
        end else if (count_down != last_dir_q) begin
            need_nxt = 1'b1;
        end else begin
            need_nxt = need_q;
        end
    end

    // Remember the direction and the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_dir_q <= DIR_UP;
            need_q     <= 1'b0;
        end else begin
            last_dir_q <= count_down;
            need_q     <= need_nxt;
        end
    end

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        need_q && !reload_stb |=> need_q);

    p_reload_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |=> !need_q);

endmodule

// File: rtl/lbac_bank_gate.sv
// Registered port-active flag: top BW bits of the next address must equal
// bank_id and no reload may be pending. The flag is registered on the same
// edge as the address, so both describe the same cycle.
// Assumes BW <= AW.
module lbac_bank_gate #(
    parameter int AW = 16,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_nxt,
    input  logic [BW-1:0] bank_id,
    input  logic          need_nxt,
    output logic          active_q
);

    localparam int TOP_LSB = AW - BW;

    logic [BW-1:0] bit_eq;

    // Per-bit bank comparison.
    for (genvar g = 0; g < BW; g++) begin : g_cmp
        assign bit_eq[g] = (addr_nxt[TOP_LSB + g] == bank_id[g]);
    end

    // Register the combined flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else begin
            active_q <= (&bit_eq) && !need_nxt;
        end
    end

    p_mismatch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_nxt[AW-1:TOP_LSB] != bank_id |=> !active_q);

    p_pending_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        need_nxt |=> !active_q);

endmodule

// File: rtl/lb_addr_counter.sv
// One port's address counter for a line buffer: reloadable, up/down,
// wrap-around, with a registered bank-match active flag.
// Assumes a synchronous active-low reset and BW <= AW.
module lb_addr_counter #(
    parameter int AW = 16,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_en,
    input  logic          reload_stb,
    input  logic          reload_mode,
    input  logic          count_down,
    input  logic [AW-1:0] reload_val,
    input  logic [BW-1:0] bank_id,
    output logic [AW-1:0] addr_q,
    output logic          port_active
);

    localparam int TOP_LSB = AW - BW;

    logic [AW-1:0] addr_nxt;
    logic          need_nxt;
    logic          need_q;

    lbac_count_core #(.AW(AW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .reload_stb  (reload_stb),
        .reload_mode (reload_mode),
        .count_down  (count_down),
        .reload_val  (reload_val),
        .addr_q      (addr_q),
        .addr_nxt    (addr_nxt)
    );

    lbac_dir_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_down (count_down),
        .reload_stb (reload_stb),
        .need_nxt   (need_nxt),
        .need_q     (need_q)
    );

    lbac_bank_gate #(.AW(AW), .BW(BW)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_nxt (addr_nxt),
        .bank_id  (bank_id),
        .need_nxt (need_nxt),
        .active_q (port_active)
    );

    p_mismatch_counts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q[AW-1:TOP_LSB] != bank_id) && step_en && !reload_stb
            |=> addr_q != $past(addr_q));

    p_active_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_active |-> !need_q);

    p_reload_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb && reload_mode && step_en |=> addr_q == $past(reload_val));

endmodule

// File: tb/lb_addr_counter_tb.sv
module lb_addr_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_en, reload_stb, reload_mode, count_down;
    logic [15:0] reload_val;
    logic [2:0]  bank_id;
    logic [15:0] addr_q;
    logic        port_active;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state, derived from the requirements.
    logic [15:0] m_addr = '0;
    logic        m_need = 1'b0;
    logic        m_last = 1'b0;
    logic        m_act  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lb_addr_counter u_dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .reload_stb(reload_stb),
        .reload_mode(reload_mode), .count_down(count_down),
        .reload_val(reload_val), .bank_id(bank_id),
        .addr_q(addr_q), .port_active(port_active)
    );

    task automatic check(input string tag);
        n_run++;
        if (addr_q !== m_addr || port_active !== m_act) begin
            n_fail++;
            $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b",
                     tag, addr_q, port_active, m_addr, m_act);
        end
    endtask

    // One clock: advance the model with the inputs held now, then compare.
    task automatic cyc(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_addr = '0; m_need = 1'b0; m_last = 1'b0; m_act = 1'b0;
        end else begin
            if (reload_stb)
                m_addr = reload_mode ? reload_val : (count_down ? 16'hFFFF : 16'h0000);
            else if (step_en)
                m_addr = count_down ? m_addr - 16'd1 : m_addr + 16'd1;
            if (reload_stb)             m_need = 1'b0;
            else if (count_down != m_last) m_need = 1'b1;
            m_last = count_down;
            m_act  = (m_addr[15:13] == bank_id) && !m_need;
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: timeout actual=expired expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; step_en = 0; reload_stb = 0; reload_mode = 0;
        count_down = 0; reload_val = 16'h5A5A; bank_id = 3'd0;
        step_en = 1'b1;
        cyc("R9 reset");
        cyc("R9 reset");
        step_en = 1'b0;
        rst_n = 1'b1;

        cyc("R6 idle match bank 0");
        reload_stb = 1; reload_mode = 1; reload_val = 16'hE000; bank_id = 3'd7;
        cyc("R1 load E000");
        step_en = 1; reload_val = 16'h1234;
        cyc("R5 reload beats step");
        reload_stb = 0; step_en = 0;
        cyc("R4 hold");
        cyc("R4 hold");
        reload_stb = 1; reload_mode = 0; reload_val = 16'hABCD; bank_id = 3'd0;
        cyc("R2 clear up");
        count_down = 1; bank_id = 3'd7;
        cyc("R2 clear down with direction change R8");
        reload_stb = 0; step_en = 1;
        cyc("R3 down step");
        count_down = 0;
        cyc("R8 direction change sets pending");
        cyc("R8 pending holds active low across wrap");
        cyc("R8 pending still held");
        reload_stb = 1; reload_mode = 1; reload_val = 16'hE005;
        cyc("R8 reload clears pending");
        reload_stb = 0; step_en = 0;
        cyc("R8 active again");

        // Mismatch keeps counting.
        reload_stb = 1; reload_mode = 0; bank_id = 3'd1;
        cyc("R2 clear for R7");
        reload_stb = 0; step_en = 1;
        for (int i = 0; i < 6; i++) cyc("R7 mismatch counts");

        // Full sweep up through every bank and the wrap.
        reload_stb = 1; reload_mode = 0; bank_id = 3'd5;
        cyc("R2 sweep start up");
        reload_stb = 0;
        for (int i = 0; i < 65536; i++) cyc("R3 R6 up sweep");

        // Full sweep down.
        count_down = 1; reload_stb = 1; bank_id = 3'd2;
        cyc("R2 sweep start down");
        reload_stb = 0;
        for (int i = 0; i < 65536; i++) cyc("R3 R6 down sweep");

        // Reset in mid-run.
        rst_n = 1'b0;
        cyc("R9 reset mid-run");
        finish_run();
    end

endmodule